// File: doc/BRIEF.md
# Shared Message Interrupt Register Bank

This block collects message-signalled interrupts. A sender writes one 32-bit word to a single write-only index register. The top three bits of that word choose one of eight 32-bit message registers. The next five bits choose which bit in that register is set to one. Each message register drives its own interrupt request line. The line is high while the register holds any set bit.

A handler reads a message register to learn which messages have arrived. The read returns the register's contents and empties the register in the same access, which lowers its request line. A separate summary register shows which message registers are non-empty. A handler can read it first and then visit only the registers that need service. Priority handling and routing of the request lines belong to the logic that consumes them.

The bus has independent write and read address ports, so a message can arrive in the same cycle as a clearing read of the same register. In that case the newly arrived bit is kept. Read data is registered: it appears on the cycle after the read strobe and holds until the next read.

Top module: `msi_bank`

## Requirements
- R1: After reset all eight message registers are zero, every request line is low and the read data is zero.
- R2: A write to offset 0x140 sets bit wdata[28:24] of message register wdata[31:29]. The bit is ORed into the bits already held, wdata[23:0] has no effect, and that register's request line is high from the cycle after the write.
- R3: A read of offset 0x10*n (n = 0..7) returns register n on the read data in the cycle after the read strobe. It also clears register n, so its request line is low from that cycle unless R6 applies.
- R4: A read of offset 0x120 returns bit n set exactly when message register n is nonzero, with bits 31:8 zero, and leaves all registers unchanged.
- R5: A write to any offset other than 0x140, including the message and summary offsets, changes no register and no request line.
- R6: When a set and a clearing read hit the same register in the same cycle, the read returns the contents from before the set, and afterwards the register holds only the newly set bit with its request line high.
- R7: A read of any other offset, including 0x140 and offsets not aligned to 0x10, returns zero and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | 12 | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_raddr | input | 12 | Read byte offset |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| msg_irq | output | 8 | One request line per message register |

## Verification
The bound checker watches every cycle for the following:
- any index write raises the addressed line on the next cycle;
- at most one register is targeted by a write decode;
- a clearing read without a colliding set drops its line;
- a collision keeps the line high;
- a cycle with neither a set nor a clear leaves every line unchanged;
- an unmapped read returns zero.

Only the bench scenarios can show the following, because each depends on the accumulated contents of the registers:
- the exact OR of bits;
- the value returned by a destructive read;
- the summary word;
- the fact that writes to read-only offsets leave contents intact.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned NUM_SLOTS  = 1 << SEL_W;
  localparam int unsigned BIT_W      = $clog2(BUS_W);
  localparam int unsigned SEL_LSB    = BUS_W - SEL_W;
  localparam int unsigned BIT_LSB    = SEL_LSB - BIT_W;
  localparam int unsigned STRIDE_LG  = 4;
  localparam logic [ADDR_W-1:0] IDX_OFF = 12'h140;
  localparam logic [ADDR_W-1:0] SUM_OFF = 12'h120;

  typedef logic [BUS_W-1:0] word_t;

  // Register select field of an index write
  function automatic logic [SEL_W-1:0] sel_field(input word_t w);
    return w[BUS_W-1 -: SEL_W];
  endfunction

  // Bit select field of an index write
  function automatic logic [BIT_W-1:0] bit_field(input word_t w);
    return w[SEL_LSB-1 -: BIT_W];
  endfunction

  // True when an offset addresses a message register
  function automatic logic slot_hit(input logic [ADDR_W-1:0] a);
    return (a[STRIDE_LG-1:0] == '0) &&
           (a[ADDR_W-1:STRIDE_LG] < (ADDR_W-STRIDE_LG)'(NUM_SLOTS));
  endfunction

  // Register number addressed by an offset
  function automatic logic [SEL_W-1:0] slot_num(input logic [ADDR_W-1:0] a);
    return a[STRIDE_LG +: SEL_W];
  endfunction
endpackage

// File: rtl/msi_wr_decode.sv
module msi_wr_decode
  import msi_bank_pkg::*;
(
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [SEL_W-1:0]     sel,
  input  logic [BIT_W-1:0]     bitn,
  output logic [NUM_SLOTS-1:0] set_req,
  output word_t                set_mask
);
  logic idx_hit;
  assign idx_hit  = wr_en && (wr_addr == IDX_OFF);
  assign set_mask = word_t'(1) << bitn;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
    assign set_req[i] = idx_hit && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/msi_slot.sv
module msi_slot
  import msi_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set,
  input  word_t set_mask,
  input  logic  clr,
  output word_t value,
  output logic  irq
);
  word_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (set || clr)
      held <= (clr ? word_t'(0) : held) | (set ? set_mask : word_t'(0));
  end

  assign value = held;
  assign irq   = |held;
endmodule

// File: rtl/msi_rd_path.sv
module msi_rd_path
  import msi_bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  word_t [NUM_SLOTS-1:0] slot_val,
  output logic [NUM_SLOTS-1:0]  clr_req,
  output logic                  rd_unmapped,
  output word_t                 rdata
);
  logic  is_slot, is_sum;
  word_t summary, rd_next;

  assign is_slot     = slot_hit(rd_addr);
  assign is_sum      = (rd_addr == SUM_OFF);
  assign rd_unmapped = rd_en && !is_slot && !is_sum;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_clr
    assign clr_req[i] = rd_en && is_slot && (slot_num(rd_addr) == SEL_W'(i));
    assign summary[i] = |slot_val[i];
  end
  assign summary[BUS_W-1:NUM_SLOTS] = '0;

  always_comb begin
    if (is_slot)     rd_next = slot_val[slot_num(rd_addr)];
    else if (is_sum) rd_next = summary;
    else             rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/msi_bank.sv
module msi_bank
  import msi_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_waddr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_raddr,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [NUM_SLOTS-1:0] msg_irq
);
  logic [NUM_SLOTS-1:0]  set_req, clr_req;
  word_t                 set_mask;
  word_t [NUM_SLOTS-1:0] slot_val;
  logic                  rd_unmapped;
  logic                  unused_low_bits;

  assign unused_low_bits = ^bus_wdata[BIT_LSB-1:0];

  msi_wr_decode u_dec (
    .wr_en   (bus_wr),
    .wr_addr (bus_waddr),
    .sel     (sel_field(bus_wdata)),
    .bitn    (bit_field(bus_wdata)),
    .set_req (set_req),
    .set_mask(set_mask)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    msi_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (set_req[i]),
      .set_mask(set_mask),
      .clr     (clr_req[i]),
      .value   (slot_val[i]),
      .irq     (msg_irq[i])
    );
  end

  msi_rd_path u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (bus_rd),
    .rd_addr    (bus_raddr),
    .slot_val   (slot_val),
    .clr_req    (clr_req),
    .rd_unmapped(rd_unmapped),
    .rdata      (bus_rdata)
  );
endmodule

// File: rtl/msi_bank_chk.sv
module msi_bank_chk
  import msi_bank_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] set_req,
  input logic [NUM_SLOTS-1:0] clr_req,
  input logic                 rd_unmapped,
  input logic [BUS_W-1:0]     bus_rdata,
  input logic [NUM_SLOTS-1:0] msg_irq
);
  AST_SET_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_req)); // R2
  AST_SET_RAISES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_req) |=> ((msg_irq & $past(set_req)) == $past(set_req))); // R2
  AST_CLEAR_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_req) && !(|(set_req & clr_req))) |=> ((msg_irq & $past(clr_req)) == '0)); // R3
  AST_COLLIDE_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_req & clr_req)) |=> (|(msg_irq & $past(set_req & clr_req)))); // R6
  AST_QUIET_LINES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_req) && !(|clr_req)) |=> $stable(msg_irq)); // R5
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (bus_rdata == '0)); // R7
endmodule

bind msi_bank msi_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_req    (set_req),
  .clr_req    (clr_req),
  .rd_unmapped(rd_unmapped),
  .bus_rdata  (bus_rdata),
  .msg_irq    (msg_irq)
);

// File: tb/tb_msi_bank.sv
`timescale 1ns/1ps
module tb_msi_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_waddr = '0, bus_raddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  msg_irq;

  int checks = 0, fails = 0;
  logic [31:0] model [8];
  logic [31:0] exp_rdata = '0;

  always #2.5 clk = ~clk;

  msi_bank dut (.*);

  function automatic logic [7:0] exp_lines();
    logic [7:0] l;
    for (int i = 0; i < 8; i++) l[i] = (model[i] != 0);
    return l;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (a == 12'h120) return {24'h0, exp_lines()};
    if (a[3:0] == 4'h0 && a < 12'h080) return model[a[6:4]];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle, driven at a falling edge and checked at the next one.
  task automatic step(input string req, input logic wr, input logic [11:0] wa,
                      input logic [31:0] wd, input logic rd, input logic [11:0] ra);
    logic [31:0] nxt [8];
    bus_wr = wr; bus_waddr = wa; bus_wdata = wd;
    bus_rd = rd; bus_raddr = ra;
    if (rd) exp_rdata = exp_read(ra);
    for (int i = 0; i < 8; i++) nxt[i] = model[i];
    if (rd && ra[3:0] == 4'h0 && ra < 12'h080) nxt[ra[6:4]] = 32'h0;
    if (wr && wa == 12'h140) nxt[wd[31:29]] = nxt[wd[31:29]] | (32'h1 << wd[28:24]);
    for (int i = 0; i < 8; i++) model[i] = nxt[i];
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk(req, {24'h0, msg_irq}, {24'h0, exp_lines()});
    if (rd) chk(req, bus_rdata, exp_rdata);
  endtask

  function automatic logic [31:0] idx_word(input int r, input int b, input logic [23:0] junk);
    return {3'(r), 5'(b), junk};
  endfunction

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {24'h0, msg_irq}, 32'h0);
    chk("R1", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 set, with junk in low bits, then OR a second bit
    step("R2", 1, 12'h140, idx_word(3, 7, 24'hABCDEF), 0, 0);
    step("R2", 1, 12'h140, idx_word(3, 31, 24'h123456), 0, 0);
    step("R4", 0, 0, 0, 1, 12'h120);
    chk("R4", bus_rdata, 32'h0000_0008);
    // R3 destructive read
    step("R3", 0, 0, 0, 1, 12'h030);
    chk("R3", bus_rdata, 32'h8000_0080);
    step("R3", 0, 0, 0, 1, 12'h030);
    chk("R3", bus_rdata, 32'h0);
    // R5 writes to read-only offsets ignored
    step("R2", 1, 12'h140, idx_word(0, 0, 0), 0, 0);
    step("R5", 1, 12'h000, 32'hFFFF_FFFF, 0, 0);
    step("R5", 1, 12'h120, 32'hFFFF_FFFF, 0, 0);
    step("R5", 1, 12'h144, 32'hFFFF_FFFF, 0, 0);
    step("R5", 0, 0, 0, 1, 12'h000);
    chk("R5", bus_rdata, 32'h1);
    // R6 collision: set and clear on register 5
    step("R2", 1, 12'h140, idx_word(5, 2, 0), 0, 0);
    step("R6", 1, 12'h140, idx_word(5, 9, 0), 1, 12'h050);
    chk("R6", bus_rdata, 32'h4);
    chk("R6", {31'h0, msg_irq[5]}, 32'h1);
    step("R6", 0, 0, 0, 1, 12'h050);
    chk("R6", bus_rdata, 32'h200);
    // R7 unmapped reads return zero, no side effect
    step("R2", 1, 12'h140, idx_word(7, 4, 0), 0, 0);
    step("R7", 0, 0, 0, 1, 12'h140);
    chk("R7", bus_rdata, 32'h0);
    step("R7", 0, 0, 0, 1, 12'h074);
    step("R7", 0, 0, 0, 1, 12'h080);
    step("R7", 0, 0, 0, 1, 12'h070);
    chk("R7", bus_rdata, 32'h10);

    // Random traffic on R2..R7
    for (int n = 0; n < 600; n++) begin
      logic [11:0] wa, ra;
      logic wr, rd;
      int k;
      wr = ($urandom % 4) != 0;
      wa = (($urandom % 5) != 0) ? 12'h140 : 12'($urandom);
      rd = ($urandom % 3) == 0;
      k = $urandom % 8;
      if (k < 5)       ra = {5'h0, 3'($urandom), 4'h0};
      else if (k == 5) ra = 12'h120;
      else if (k == 6) ra = 12'h140;
      else             ra = 12'($urandom);
      step("R2-R7 random", wr, wa, $urandom, rd, ra);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule